// File: doc/BRIEF.md
# Temperature-Indexed DAC Setpoint Lookup

This block turns a signed temperature reading, in whole degrees Celsius, into a DAC setpoint for each of two independent channels. Each channel owns two tables of 72 entries, one entry for every 2 °C step starting at -40 °C. The first table holds an unsigned base setpoint. The second holds a signed correction that is added to the base. The temperature is clamped to the range -40 °C to +102 °C before the entry number is formed. The sum of base and correction is saturated to the DAC range, 0 to full scale.

All four tables are written through one register write port, which carries a channel number, a table select, an entry number and a data byte. Each channel starts a lookup on its own temperature strobe. The result is registered at that clock edge and appears one clock after the strobe, marked by a single-cycle valid pulse. The value then stays on the output until the next strobe on that channel.

Each channel has a small state machine with three states. `ST_EMPTY` holds from reset until the first lookup. `ST_FRESH` is the cycle in which a new result is shown. `ST_HOLD` is the period in which that result is kept. The transitions are:
- `ST_EMPTY`→`ST_FRESH` on a strobe.
- `ST_FRESH`→`ST_FRESH` on back-to-back strobes.
- `ST_FRESH`→`ST_HOLD` when there is no strobe.
- `ST_HOLD`→`ST_FRESH` on the next strobe.
- `ST_EMPTY` and `ST_HOLD` stay where they are when there is no strobe.

Top module: `dac_lut_top`

## Requirements
- R1: After reset, every DAC output is 0, every valid flag is 0 and every table entry is 0, so a lookup made with no prior writes returns 0.
- R2: The entry number is floor((T + 40) / 2) for T in -40..102. Any T below -40 uses entry 0.
- R3: Any T above +102 uses entry 71, which is the last entry.
- R4: The result is base + offset. The base is an unsigned byte and the offset is a two's-complement byte. The result is forced to 0 when the sum is negative and to 255 when the sum is above 255.
- R5: When a channel's strobe is high at a clock edge, that channel's new result and a valid flag of 1 are visible after that edge. The valid flag is 0 after any edge at which the strobe was low.
- R6: A channel's DAC output does not change between its strobes.
- R7: The channels are independent. A strobe updates only its own channel, and a write to one channel's tables has no effect on the other channel's results.
- R8: The write port stores `wr_data_i` when `wr_en_i` is 1. `wr_ch_i` picks the channel. `wr_tbl_i` = 0 selects the base table and 1 selects the offset table. A write with `wr_idx_i` of 72 or more is ignored.
- R9: When a table write and a strobe fall on the same clock edge, that lookup uses the old table contents. The new value is used from the next lookup on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| temp_i | input | 20 | Signed temperatures in °C. Channel c uses bits c*10 +: 10 |
| temp_vld_i | input | 2 | Per-channel lookup strobe |
| wr_en_i | input | 1 | Table write enable |
| wr_ch_i | input | 1 | Channel of the write |
| wr_tbl_i | input | 1 | 0 = base table, 1 = offset table |
| wr_idx_i | input | 7 | Entry number of the write |
| wr_data_i | input | 8 | Byte to store |
| dac_o | output | 16 | Setpoints. Channel c uses bits c*8 +: 8 |
| dac_vld_o | output | 2 | Per-channel one-cycle result-valid pulse |

## Verification
The bench sweeps temperatures across both clamp edges and across each odd/even pair of degrees.
- A design that offsets or rounds the entry number wrongly returns the neighbouring entry's value.
- A design that wraps instead of clamping reads a far-away entry at extreme temperatures.

Entries are loaded with base and offset pairs that overflow above 255 and that go below 0. A sum that wraps instead of saturating therefore shows up as a small value or a large value in the wrong place.

Writes beyond entry 71 are sent to catch an address decode that aliases onto real entries. A write is issued on the same edge as a strobe to catch a lookup that sees the new data too early. Strobes are given to one channel only to catch cross-channel leakage, and long idle stretches catch an output that drifts between strobes.

// File: rtl/dac_lut_pkg.sv
package dac_lut_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_FRESH = 2'd1,
        ST_HOLD  = 2'd2
    } chan_st_e;

    typedef enum logic {
        TBL_BASE = 1'b0,
        TBL_OFS  = 1'b1
    } tbl_sel_e;

endpackage

// File: rtl/temp_index.sv
module temp_index #(
    parameter int TEMP_W  = 10,
    parameter int IDX_W   = 7,
    parameter int STEP_LG = 1,
    parameter int T_MIN   = -40,
    parameter int T_MAX   = 102
) (
    input  logic signed [TEMP_W-1:0] temp,
    output logic        [IDX_W-1:0]  idx
);
    localparam logic signed [TEMP_W-1:0] LO = TEMP_W'(T_MIN);
    localparam logic signed [TEMP_W-1:0] HI = TEMP_W'(T_MAX);

    logic signed [TEMP_W-1:0] clamped;
    logic        [TEMP_W:0]   off;

    always_comb begin
        if (temp < LO) begin
            clamped = LO;
        end else if (temp > HI) begin
            clamped = HI;
        end else begin
            clamped = temp;
        end
    end

    assign off = {clamped[TEMP_W-1], clamped} - {LO[TEMP_W-1], LO};
    assign idx = off[IDX_W+STEP_LG-1:STEP_LG];

endmodule

// File: rtl/lut_bank.sv
module lut_bank #(
    parameter int N_ENT = 72,
    parameter int W     = 8,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data
);
    logic [W-1:0] mem [N_ENT];
    logic         wr_ok;

    assign wr_ok = wr_en && (int'(wr_idx) < N_ENT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_ok) begin
            mem[wr_idx] <= wr_data;
        end
    end

    always_comb begin
        if (int'(rd_idx) < N_ENT) begin
            rd_data = mem[rd_idx];
        end else begin
            rd_data = '0;
        end
    end

    AST_RD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rd_idx) < N_ENT); // R3

endmodule

// File: rtl/sat_add.sv
module sat_add #(
    parameter int DAC_W = 8,
    parameter int OFS_W = 8
) (
    input  logic [DAC_W-1:0] base,
    input  logic [OFS_W-1:0] ofs,
    output logic [DAC_W-1:0] result
);
    localparam int SUM_W = DAC_W + 2;
    localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << DAC_W) - 1);

    logic signed [SUM_W-1:0] sum;

    always_comb begin
        sum = $signed({2'b00, base}) + $signed({{(SUM_W-OFS_W){ofs[OFS_W-1]}}, ofs});
        if (sum < 0) begin
            result = '0;
        end else if (sum > MAXV) begin
            result = '1;
        end else begin
            result = sum[DAC_W-1:0];
        end
    end

endmodule

// File: rtl/chan_fsm.sv
module chan_fsm
    import dac_lut_pkg::*;
#(
    parameter int DAC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [DAC_W-1:0] result,
    output logic [DAC_W-1:0] dac,
    output logic             vld
);
    chan_st_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_EMPTY: state_d = strobe ? ST_FRESH : ST_EMPTY;
            ST_FRESH: state_d = strobe ? ST_FRESH : ST_HOLD;
            ST_HOLD:  state_d = strobe ? ST_FRESH : ST_HOLD;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac <= '0;
        end else if (strobe) begin
            dac <= result;
        end
    end

    assign vld = (state_q == ST_FRESH);

    AST_VLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> vld); // R5
    AST_NO_SPURIOUS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> !vld); // R5
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(dac)); // R6

endmodule

// File: rtl/dac_lut_top.sv
module dac_lut_top
    import dac_lut_pkg::*;
#(
    parameter int N_CH    = 2,
    parameter int TEMP_W  = 10,
    parameter int DAC_W   = 8,
    parameter int OFS_W   = 8,
    parameter int N_ENT   = 72,
    parameter int T_MIN   = -40,
    parameter int STEP_LG = 1,
    localparam int IDX_W  = $clog2(N_ENT),
    localparam int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int T_MAX  = T_MIN + (N_ENT - 1) * (1 << STEP_LG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_CH*TEMP_W-1:0]  temp_i,
    input  logic [N_CH-1:0]         temp_vld_i,
    input  logic                    wr_en_i,
    input  logic [CH_W-1:0]         wr_ch_i,
    input  logic                    wr_tbl_i,
    input  logic [IDX_W-1:0]        wr_idx_i,
    input  logic [DAC_W-1:0]        wr_data_i,
    output logic [N_CH*DAC_W-1:0]   dac_o,
    output logic [N_CH-1:0]         dac_vld_o
);

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic signed [TEMP_W-1:0] t_c;
        logic [IDX_W-1:0]         idx_c;
        logic                     we_base, we_ofs;
        logic [DAC_W-1:0]         base_c;
        logic [OFS_W-1:0]         ofs_c;
        logic [DAC_W-1:0]         sum_c;
        logic [DAC_W-1:0]         dac_c;
        logic                     vld_c;

        assign t_c     = $signed(temp_i[c*TEMP_W +: TEMP_W]);
        assign we_base = wr_en_i && (wr_ch_i == CH_W'(c)) && (wr_tbl_i == TBL_BASE);
        assign we_ofs  = wr_en_i && (wr_ch_i == CH_W'(c)) && (wr_tbl_i == TBL_OFS);

        temp_index #(
            .TEMP_W (TEMP_W),
            .IDX_W  (IDX_W),
            .STEP_LG(STEP_LG),
            .T_MIN  (T_MIN),
            .T_MAX  (T_MAX)
        ) i_index (
            .temp(t_c),
            .idx (idx_c)
        );

        lut_bank #(
            .N_ENT(N_ENT),
            .W    (DAC_W),
            .IDX_W(IDX_W)
        ) i_base (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (we_base),
            .wr_idx (wr_idx_i),
            .wr_data(wr_data_i),
            .rd_idx (idx_c),
            .rd_data(base_c)
        );

        lut_bank #(
            .N_ENT(N_ENT),
            .W    (OFS_W),
            .IDX_W(IDX_W)
        ) i_ofs (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (we_ofs),
            .wr_idx (wr_idx_i),
            .wr_data(wr_data_i[OFS_W-1:0]),
            .rd_idx (idx_c),
            .rd_data(ofs_c)
        );

        sat_add #(
            .DAC_W(DAC_W),
            .OFS_W(OFS_W)
        ) i_sat (
            .base  (base_c),
            .ofs   (ofs_c),
            .result(sum_c)
        );

        chan_fsm #(
            .DAC_W(DAC_W)
        ) i_fsm (
            .clk   (clk),
            .rst_n (rst_n),
            .strobe(temp_vld_i[c]),
            .result(sum_c),
            .dac   (dac_c),
            .vld   (vld_c)
        );

        assign dac_o[c*DAC_W +: DAC_W] = dac_c;
        assign dac_vld_o[c]            = vld_c;

        AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (t_c < T_MIN) |-> (idx_c == '0)); // R2
        AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (t_c > T_MAX) |-> (int'(idx_c) == N_ENT - 1)); // R3
        AST_SAT_UP: assert property (@(posedge clk) disable iff (!rst_n)
            !ofs_c[OFS_W-1] |-> (sum_c >= base_c)); // R4
        AST_SAT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
            ofs_c[OFS_W-1] |-> (sum_c <= base_c)); // R4
        AST_ZERO_OFS: assert property (@(posedge clk) disable iff (!rst_n)
            (ofs_c == '0) |-> (sum_c == base_c)); // R4
    end

endmodule

// File: tb/test_dac_lut_top.sv
`timescale 1ns/1ps
module test_dac_lut_top;
    localparam int TW = 10;
    localparam int DW = 8;
    localparam int NE = 72;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2*TW-1:0] temp_i = '0;
    logic [1:0]    temp_vld_i = '0;
    logic          wr_en_i = 1'b0;
    logic [0:0]    wr_ch_i = '0;
    logic          wr_tbl_i = 1'b0;
    logic [6:0]    wr_idx_i = '0;
    logic [7:0]    wr_data_i = '0;
    logic [2*DW-1:0] dac_o;
    logic [1:0]    dac_vld_o;

    always #2.5 clk = ~clk;

    dac_lut_top i_dac_lut_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .temp_i    (temp_i),
        .temp_vld_i(temp_vld_i),
        .wr_en_i   (wr_en_i),
        .wr_ch_i   (wr_ch_i),
        .wr_tbl_i  (wr_tbl_i),
        .wr_idx_i  (wr_idx_i),
        .wr_data_i (wr_data_i),
        .dac_o     (dac_o),
        .dac_vld_o (dac_vld_o)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string phase = "R1";
    bit    done = 0;
    int    m_base [2][NE];
    int    m_ofs  [2][NE];
    int    e_dac  [2];
    int    e_vld  [2];

    function automatic int ref_idx(int t);
        int tc = t;
        if (tc < -40) tc = -40;
        if (tc > 102) tc = 102;
        return (tc + 40) / 2;
    endfunction

    function automatic int ref_val(int c, int t);
        int i = ref_idx(t);
        int o = (m_ofs[c][i] > 127) ? m_ofs[c][i] - 256 : m_ofs[c][i];
        int v = m_base[c][i] + o;
        if (v < 0) v = 0;
        if (v > 255) v = 255;
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                e_dac[c] = 0;
                e_vld[c] = 0;
                for (int i = 0; i < NE; i++) begin
                    m_base[c][i] = 0;
                    m_ofs[c][i]  = 0;
                end
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                e_vld[c] = int'(temp_vld_i[c]);
                if (temp_vld_i[c]) e_dac[c] = ref_val(c, int'($signed(temp_i[c*TW +: TW])));
            end
            if (wr_en_i && int'(wr_idx_i) < NE) begin
                if (wr_tbl_i) m_ofs[wr_ch_i][wr_idx_i] = int'(wr_data_i);
                else          m_base[wr_ch_i][wr_idx_i] = int'(wr_data_i);
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int c = 0; c < 2; c++) begin
                chk({phase, " model dac"}, int'(dac_o[c*DW +: DW]), e_dac[c]);
                chk({phase, " model vld R5"}, int'(dac_vld_o[c]), e_vld[c]);
            end
        end
    end

    task automatic wr(int c, int tb, int i, int d);
        @(negedge clk); #1;
        wr_en_i = 1'b1; wr_ch_i = 1'(c); wr_tbl_i = 1'(tb);
        wr_idx_i = 7'(i); wr_data_i = 8'(d);
        @(negedge clk); #1;
        wr_en_i = 1'b0;
    endtask

    task automatic look(int t0, bit v0, int t1, bit v1);
        @(negedge clk); #1;
        temp_i[0 +: TW]  = TW'(t0);
        temp_i[TW +: TW] = TW'(t1);
        temp_vld_i = {v1, v0};
        @(negedge clk); #1;
        temp_vld_i = '0;
    endtask

    function automatic int dac_of(int c);
        return int'(dac_o[c*DW +: DW]);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired in phase %s (R5)", phase);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int held;
        repeat (5) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        phase = "R1";
        chk("R1 reset dac0", dac_of(0), 0);
        chk("R1 reset dac1", dac_of(1), 0);
        chk("R1 reset vld", int'(dac_vld_o), 0);
        look(25, 1, -5, 1);
        chk("R1 empty table ch0", dac_of(0), 0);
        chk("R1 empty table ch1", dac_of(1), 0);

        phase = "R8";
        for (int c = 0; c < 2; c++) begin
            for (int i = 0; i < NE; i++) begin
                wr(c, 0, i, (i * 7 + c * 40 + 3) % 256);
                wr(c, 1, i, ((((i * 5 + c) % 41) - 20) + 256) % 256);
            end
        end
        wr(0, 0, 71, 250); wr(0, 1, 71, 20);
        wr(0, 0, 0, 5);    wr(0, 1, 0, 246);
        wr(1, 0, 71, 10);  wr(1, 1, 71, 236);
        wr(1, 0, 0, 200);  wr(1, 1, 0, 100);

        phase = "R3";
        look(200, 1, 300, 1);
        chk("R3 clamp high ch0 saturates up R4", dac_of(0), 255);
        chk("R3 clamp high ch1 saturates down R4", dac_of(1), 0);
        look(102, 1, 103, 1);
        chk("R3 edge 102 ch0", dac_of(0), 255);
        chk("R3 edge 103 ch1", dac_of(1), 0);

        phase = "R2";
        look(-41, 1, -100, 1);
        chk("R2 clamp low ch0 R4", dac_of(0), 0);
        chk("R2 clamp low ch1 R4", dac_of(1), 255);
        look(-39, 1, -38, 1);
        chk("R2 -39 uses entry 0", dac_of(0), 0);
        chk("R2 -38 uses entry 1", dac_of(1), 36);
        look(0, 0, -37, 1);
        chk("R2 -37 uses entry 1", dac_of(1), 36);
        look(0, 0, -36, 1);
        chk("R2 -36 uses entry 2", dac_of(1), 48);

        phase = "R2/R3/R4 sweep";
        for (int t = -50; t <= 110; t++) look(t, 1, 60 - t, 1);

        phase = "R6";
        look(30, 1, 31, 1);
        held = dac_of(0);
        repeat (12) @(negedge clk);
        #1 chk("R6 hold ch0", dac_of(0), held);

        phase = "R7";
        held = dac_of(1);
        look(-20, 1, 0, 0);
        chk("R7 ch1 untouched by ch0 strobe", dac_of(1), held);
        chk("R7 ch1 no vld", int'(dac_vld_o[1]), 0);
        wr(1, 0, 10, 77);
        look(-20, 1, 0, 0);
        chk("R7 ch0 unaffected by ch1 write", dac_of(0), ref_val(0, -20));

        phase = "R8";
        for (int i = NE; i < 128; i++) begin
            wr(0, 0, i, 170); wr(0, 1, i, 170);
            wr(1, 0, i, 170); wr(1, 1, i, 170);
        end
        for (int t = -40; t <= 102; t += 2) look(t, 1, t + 1, 1);
        look(200, 1, -100, 1);
        chk("R8 out-of-range writes ignored ch0", dac_of(0), 255);
        chk("R8 out-of-range writes ignored ch1", dac_of(1), 255);
        wr(1, 1, 5, 0); wr(1, 0, 5, 123);
        look(0, 0, -30, 1);
        chk("R8 base write lands", dac_of(1), 123);

        phase = "R9";
        wr(0, 1, 35, 0); wr(0, 0, 35, 60);
        @(negedge clk); #1;
        wr_en_i = 1'b1; wr_ch_i = 1'b0; wr_tbl_i = 1'b0;
        wr_idx_i = 7'd35; wr_data_i = 8'd100;
        temp_i[0 +: TW] = TW'(30);
        temp_vld_i = 2'b01;
        @(negedge clk); #1;
        wr_en_i = 1'b0; temp_vld_i = '0;
        chk("R9 same-edge lookup sees old", dac_of(0), 60);
        look(31, 1, 0, 0);
        chk("R9 next lookup sees new", dac_of(0), 100);

        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule